// File: doc/BRIEF.md
# Reference Phase Picker

The block chooses one of several equally spaced phases of a halved reference clock. The choice is made so that the rising edge of the chosen phase falls 45 to 90 degrees after the rising edge of the halved feedback signal from the divided oscillator. The chosen phase then drives the reference side of a period comparator. Keeping that lag inside the window keeps the comparator's charge pumps away from their dead zone. In the intended use there are eight phases of a reference near 20 MHz, made from a 40 MHz source. The phases come from outside the block.

While `en` is high, each rising edge of `fb_half` freezes the levels of all phases. The phases are delayed copies of one square wave, so the frozen pattern is a circular run of ones followed by a run of zeros. The block finds the zero that follows the run of ones and picks the phase one step after that zero. This gives the target index. The multiplexer select walks toward the target one position at a time. Each move happens only in a cycle where both the phase being left and the phase being entered are low, so the selected output never shows a runt pulse. `sel_valid` reports that the target has held for two snapshots in a row and that the select has arrived at it.

All inputs are treated as levels sampled on `clk`, and `clk` must run well above the phase rate. `NPH` must be a power of two. There is no data stream and therefore no back-pressure. Every pin is a plain level.

Top module: `refphase_picker`

## Requirements
- R1: While `rst_n` is low, `ph_idx` is 0 and `sel_valid` is 0.
- R2: Phase k+1 is phase k delayed by 360/NPH degrees of the halved reference. On a clock edge where `en` is high and `fb_half` is first seen high, the block finds the lowest k for which `ref_ph[k]` is 0 and `ref_ph[k-1 mod NPH]` is 1. The target index becomes k+1 mod NPH. With eight phases, the selected phase therefore rises more than 45 and at most 90 degrees after `fb_half` rises.
- R3: `ph_sel_out` equals `ref_ph[ph_idx]` at all times, with no register in the path.
- R4: `ph_idx` changes only at a clock edge where `ref_ph` at both the old index and the new index is sampled low. Each change is one position (±1 mod NPH) toward the target, taking the shorter way round, and going upward when both ways are equal.
- R5: `sel_valid` is 1 only when the last two snapshots gave the same target and `ph_idx` equals that target. It stays 1 for as long as later snapshots keep agreeing.
- R6: While `en` is low, `sel_valid` is 0 in the same cycle, no snapshot is taken, and `ph_idx` holds its value even if the phase relationship changes.
- R7: When `en` is raised again, the agreement history is empty. `sel_valid` stays 0 until two new snapshots have agreed.
- R8: A snapshot with no 1-to-0 boundary (for example, all phases low) clears the history. `sel_valid` drops, and `ph_idx` holds its value.
- R9: If consecutive snapshots give different targets, as happens when `fb_half` and the reference differ in frequency, `sel_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables snapshots and select moves |
| ref_ph | input | NPH (8) | Phases of the halved reference; bit k lags bit k-1 by 360/NPH degrees |
| fb_half | input | 1 | Halved divided-oscillator signal; its rising edge triggers a snapshot |
| ph_sel_out | output | 1 | The selected reference phase |
| ph_idx | output | log2(NPH) (3) | Current multiplexer select |
| sel_valid | output | 1 | Target stable over two snapshots and reached |

## Verification
The hardest case to reach is a target that sits exactly opposite the current select. These two phases are never low together, so a direct jump would either glitch or stall. The stimulus moves the feedback edge from a position that selects phase 4 to one that selects phase 0. It then watches every change of `ph_idx` to confirm that the select walks through 5, 6 and 7, one step at a time, each while both phases are low. A second hard case needs the snapshots to disagree every time. The stimulus gets this by running `fb_half` at a period of 20 clocks against a reference period of 16, which moves the target by two positions at each edge.

// File: rtl/rpp_pkg.sv
package rpp_pkg;

  // History of target agreement between successive snapshots.
  typedef enum logic [1:0] {
    Q_EMPTY = 2'd0,  // no usable snapshot since enable / bad snapshot
    Q_ONE   = 2'd1,  // one snapshot held, not yet confirmed
    Q_MATCH = 2'd2   // last two snapshots agreed
  } qual_state_e;

  localparam int unsigned RPP_NPH_DEFAULT = 8;

endpackage

// File: rtl/rpp_snap.sv
// Detects the feedback rising edge, freezes the phase pattern and locates
// the phase that follows the first high-to-low boundary.
module rpp_snap #(
  parameter int unsigned NPH  = 8,
  parameter int unsigned IDXW = $clog2(NPH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NPH-1:0]  ref_ph,
  input  logic            fb_half,
  output logic            snap_stb,
  output logic            snap_good,
  output logic [IDXW-1:0] snap_idx
);

  logic            fb_q;
  logic            fb_rise;
  logic            good_c;
  logic [IDXW-1:0] idx_c;
  logic [NPH-1:0]  boundary;

  assign fb_rise = en & fb_half & ~fb_q;

  // boundary[k]: phase k low while its predecessor is high
  for (genvar k = 0; k < NPH; k++) begin : g_bnd
    localparam int unsigned PREV = (k + NPH - 1) % NPH;
    assign boundary[k] = ~ref_ph[k] & ref_ph[PREV];
  end

  // lowest boundary wins; pick the phase after it
  always_comb begin
    good_c = 1'b0;
    idx_c  = '0;
    for (int k = NPH - 1; k >= 0; k--) begin
      if (boundary[k]) begin
        good_c = 1'b1;
        idx_c  = IDXW'((k + 1) % NPH);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q      <= 1'b0;
      snap_stb  <= 1'b0;
      snap_good <= 1'b0;
      snap_idx  <= '0;
    end else begin
      fb_q     <= fb_half;
      snap_stb <= fb_rise;
      if (fb_rise) begin
        snap_good <= good_c;
        snap_idx  <= idx_c;
      end
    end
  end

endmodule

// File: rtl/rpp_qual.sv
// Holds the latest target and whether it was confirmed by a second snapshot.
module rpp_qual #(
  parameter int unsigned NPH  = 8,
  parameter int unsigned IDXW = $clog2(NPH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            snap_stb,
  input  logic            snap_good,
  input  logic [IDXW-1:0] snap_idx,
  output logic            tgt_ok,
  output logic            tgt_agree,
  output logic [IDXW-1:0] tgt_idx
);
  import rpp_pkg::*;

  qual_state_e     state_q, state_d;
  logic [IDXW-1:0] tgt_q, tgt_d;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    if (!en) begin
      state_d = Q_EMPTY;
    end else if (snap_stb) begin
      if (!snap_good) begin
        state_d = Q_EMPTY;
      end else if (state_q == Q_EMPTY) begin
        state_d = Q_ONE;
        tgt_d   = snap_idx;
      end else if (snap_idx == tgt_q) begin
        state_d = Q_MATCH;
      end else begin
        state_d = Q_ONE;
        tgt_d   = snap_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= Q_EMPTY;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
    end
  end

  assign tgt_ok    = (state_q != Q_EMPTY);
  assign tgt_agree = (state_q == Q_MATCH);
  assign tgt_idx   = tgt_q;

endmodule

// File: rtl/rpp_switch.sv
// Walks the select one position at a time toward the target, moving only
// while both neighbouring phases are low, and drives the output mux.
module rpp_switch #(
  parameter int unsigned NPH  = 8,
  parameter int unsigned IDXW = $clog2(NPH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NPH-1:0]  ref_ph,
  input  logic            tgt_ok,
  input  logic [IDXW-1:0] tgt_idx,
  output logic [IDXW-1:0] cur_idx,
  output logic            sel_out
);

  localparam logic [IDXW:0] HALF = (IDXW+1)'(NPH / 2);

  logic [IDXW-1:0] cur_q;
  logic [IDXW-1:0] fwd_dist;
  logic [IDXW-1:0] nxt_idx;
  logic            go_up;
  logic            move;
  logic [NPH-1:0]  cur_oh;
  logic [NPH-1:0]  nxt_oh;

  assign fwd_dist = tgt_idx - cur_q;
  assign go_up    = ({1'b0, fwd_dist} <= HALF);
  assign nxt_idx  = go_up ? cur_q + 1'b1 : cur_q - 1'b1;

  for (genvar k = 0; k < NPH; k++) begin : g_dec
    assign cur_oh[k] = (cur_q   == IDXW'(k));
    assign nxt_oh[k] = (nxt_idx == IDXW'(k));
  end

  assign move = en & tgt_ok & (tgt_idx != cur_q)
              & ~|(cur_oh & ref_ph) & ~|(nxt_oh & ref_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur_q <= '0;
    else if (move) cur_q <= nxt_idx;
  end

  // AND-OR mux: one decoded term per phase
  assign sel_out = |(cur_oh & ref_ph);
  assign cur_idx = cur_q;

endmodule

// File: rtl/refphase_picker.sv
module refphase_picker #(
  parameter int unsigned NPH  = rpp_pkg::RPP_NPH_DEFAULT,
  parameter int unsigned IDXW = $clog2(NPH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NPH-1:0]  ref_ph,
  input  logic            fb_half,
  output logic            ph_sel_out,
  output logic [IDXW-1:0] ph_idx,
  output logic            sel_valid
);

  logic            snap_stb;
  logic            snap_good;
  logic [IDXW-1:0] snap_idx;
  logic            tgt_ok;
  logic            tgt_agree;
  logic [IDXW-1:0] tgt_idx;
  logic [IDXW-1:0] cur_idx;

  rpp_snap #(.NPH(NPH), .IDXW(IDXW)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ref_ph    (ref_ph),
    .fb_half   (fb_half),
    .snap_stb  (snap_stb),
    .snap_good (snap_good),
    .snap_idx  (snap_idx)
  );

  rpp_qual #(.NPH(NPH), .IDXW(IDXW)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .snap_stb  (snap_stb),
    .snap_good (snap_good),
    .snap_idx  (snap_idx),
    .tgt_ok    (tgt_ok),
    .tgt_agree (tgt_agree),
    .tgt_idx   (tgt_idx)
  );

  rpp_switch #(.NPH(NPH), .IDXW(IDXW)) u_sw (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .ref_ph  (ref_ph),
    .tgt_ok  (tgt_ok),
    .tgt_idx (tgt_idx),
    .cur_idx (cur_idx),
    .sel_out (ph_sel_out)
  );

  assign ph_idx    = cur_idx;
  assign sel_valid = en & tgt_agree & (cur_idx == tgt_idx);

endmodule

// File: rtl/refphase_picker_chk.sv
module refphase_picker_chk #(
  parameter int unsigned NPH  = 8,
  parameter int unsigned IDXW = $clog2(NPH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [NPH-1:0]  ref_ph,
  input logic            ph_sel_out,
  input logic [IDXW-1:0] ph_idx,
  input logic            sel_valid
);

  logic [NPH-1:0]  ph_d;
  logic [IDXW-1:0] idx_d;
  logic            vld_d;
  logic            primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_d   <= '0;
      idx_d  <= '0;
      vld_d  <= 1'b0;
      primed <= 1'b0;
    end else begin
      ph_d   <= ref_ph;
      idx_d  <= ph_idx;
      vld_d  <= sel_valid;
      primed <= 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (ph_idx == '0 && !sel_valid);
    end
  end

  a_r3_mux_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    ph_sel_out == ref_ph[ph_idx]);

  a_r4_switch_low: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && ph_idx != idx_d) |-> (!ph_d[idx_d] && !ph_d[ph_idx]));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && ph_idx != idx_d) |->
      (ph_idx == idx_d + 1'b1 || ph_idx == idx_d - 1'b1));

  a_r5_valid_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && sel_valid && vld_d) |-> (ph_idx == idx_d));

  a_r6_en_gates_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !sel_valid);

  a_r6_idx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> $stable(ph_idx));

endmodule

bind refphase_picker refphase_picker_chk #(.NPH(NPH), .IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .ref_ph     (ref_ph),
  .ph_sel_out (ph_sel_out),
  .ph_idx     (ph_idx),
  .sel_valid  (sel_valid)
);

// File: tb/sim_refphase_picker.sv
`timescale 1ns/1ps
module sim_refphase_picker;

  localparam int CLK_PER = 10;
  localparam int NPH     = 8;
  localparam int IDXW    = 3;
  localparam int RPER    = 16;   // halved-reference period in clocks
  localparam int NVEC    = 9;

  // {feedback rise position within reference period, expected index}
  localparam int VEC_OFF [NVEC] = '{0, 3, 5, 13, 8, 11, 14, 15, 6};
  localparam int VEC_EXP [NVEC] = '{2, 3, 4, 0,  6, 7,  1,  1,  5};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en = 1'b0;
  logic [NPH-1:0]  ref_ph = '0;
  logic            fb_half = 1'b0;
  logic            ph_sel_out;
  logic [IDXW-1:0] ph_idx;
  logic            sel_valid;

  int rcnt = 0, dcnt = 0, off = 0;
  bit kill = 0, drift = 0, done = 0;
  int checks = 0, fails = 0;

  refphase_picker u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ref_ph(ref_ph), .fb_half(fb_half),
    .ph_sel_out(ph_sel_out), .ph_idx(ph_idx), .sel_valid(sel_valid)
  );

  always #(CLK_PER/2) clk = ~clk;

  // phase and feedback generator, updated away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      rcnt = (rcnt + 1) % RPER;
      dcnt = (dcnt + 1) % 20;
      for (int k = 0; k < NPH; k++)
        ref_ph[k] = kill ? 1'b0 : (((rcnt - 2*k) & (RPER-1)) < RPER/2);
      if (drift) fb_half = (dcnt < 10);
      else       fb_half = (((rcnt - off) & (RPER-1)) < RPER/2);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // R4 monitor: every select change is a single step made while both phases are low
  initial begin
    logic [IDXW-1:0] last;
    bit seen = 0;
    forever begin
      @(posedge clk); #2;
      if (seen && rst_n && ph_idx != last) begin
        chk(!ref_ph[last] && !ref_ph[ph_idx], "R4 both low at switch",
            {ref_ph[last], ref_ph[ph_idx]}, 0);
        chk(ph_idx == last + 1'b1 || ph_idx == last - 1'b1, "R4 single step",
            int'(ph_idx), int'(last + 1'b1));
      end
      last = ph_idx;
      seen = 1;
    end
  end

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int highs;
    step(5);
    chk(ph_idx == 0, "R1 idx in reset", ph_idx, 0);
    chk(!sel_valid, "R1 valid in reset", sel_valid, 0);
    chk(ph_sel_out == ref_ph[0], "R3 mux in reset", ph_sel_out, ref_ph[0]);
    rst_n = 1'b1;
    step(2);
    en = 1'b1;

    // R2/R3/R5: expected index = floor(off/2)+2 mod 8 (phase after first low one)
    for (int v = 0; v < NVEC; v++) begin
      off = VEC_OFF[v];
      step(150);
      chk(ph_idx == IDXW'(VEC_EXP[v]), "R2 selected index", ph_idx, VEC_EXP[v]);
      chk(sel_valid, "R5 valid after agreement", sel_valid, 1);
      chk(ph_sel_out == ref_ph[ph_idx], "R3 output follows select",
          ph_sel_out, ref_ph[ph_idx]);
    end

    // R6: enable low
    en = 1'b0;
    step(1);
    chk(!sel_valid, "R6 valid drops with enable", sel_valid, 0);
    off = 0;
    step(60);
    chk(ph_idx == 5, "R6 index held while disabled", ph_idx, 5);
    off = 6;
    step(40);
    // R7: history cleared
    en = 1'b1;
    step(10);
    chk(!sel_valid, "R7 no valid before two snapshots", sel_valid, 0);
    step(50);
    chk(sel_valid, "R7 valid after two snapshots", sel_valid, 1);
    chk(ph_idx == 5, "R7 index kept", ph_idx, 5);

    // R8: phases absent
    kill = 1;
    step(40);
    chk(!sel_valid, "R8 bad snapshot clears valid", sel_valid, 0);
    chk(ph_idx == 5, "R8 index held on bad snapshot", ph_idx, 5);
    kill = 0;
    step(80);
    chk(sel_valid, "R8 recovers", sel_valid, 1);

    // R9: frequency mismatch
    drift = 1;
    step(40);
    highs = 0;
    for (int c = 0; c < 200; c++) begin
      step(1);
      if (sel_valid) highs++;
    end
    chk(highs == 0, "R9 valid stays low on disagreement", highs, 0);
    drift = 0;
    step(150);
    chk(sel_valid && ph_idx == 5, "R9 relock after mismatch", ph_idx, 5);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule